// File: doc/BRIEF.md
# Register-Pair Load/Store Sequencer

This block runs 64-bit load and store operations on a 32-bit core whose data memory port is 32 bits wide. A decoded request carries a base register value, a sign-extended 12-bit offset and the index of an even/odd register pair. The block issues two 32-bit accesses back to back. The low word goes to or comes from the lower address, and the high word uses the address four bytes above it.

On a load, the block holds both returned words. It then updates the even register (low word) and the odd register (high word) together through a dual-register write port in one cycle. If either half returns a bus error, no register is written. On a store, the block captures the pair from the register file when it accepts the request, then sends the two words in turn. The halves of a store are not atomic, so a fault on the high half leaves the low word already in memory.

Register zero gets special treatment. A load to the x0 pair still performs both reads, but it writes nothing, and x1 in particular is left unchanged. A store from the x0 pair sends zero for both words. An odd pair index is illegal and causes no bus traffic.

Top module: `pair_ldst_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. `busy` rises in the cycle after acceptance and falls after the final result pulse.
- R2: The first access uses address base + sign-extended offset, and the second uses that address + 4.
- R3: A store drives `mem_we`=1 and sends the even register first, then the odd register. A store from pair index 0 sends 0 in both accesses.
- R4: After a successful load, `rf_we` is high for exactly one cycle, the cycle after the second response. In that cycle `rf_wr_idx` is the pair index, `rf_wr_lo` is the first word read and `rf_wr_hi` is the second.
- R5: A response with `mem_err`=1 on either half ends the operation. In the following cycle `fault` pulses for one cycle with `fault_addr` set to the failing address, and a load writes no register.
- R6: A load to pair index 0 performs both reads, asserts `done`, and never asserts `rf_we`, so x1 keeps its value.
- R7: An odd pair index causes an `illegal` pulse in the cycle after acceptance, and issues no memory access.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values.
- R9: `done` pulses for one cycle, the cycle after the second half completes without error, for both loads and stores.
- R10: If the first half of an access faults, no second access is issued. If a store faults on its second half, the first word stays written in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_store | input | 1 | 1 = store pair, 0 = load pair |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed byte offset |
| req_pair | input | 5 | Even register index of the pair |
| rf_rd_idx | output | 5 | Pair index presented to the register file read port |
| rf_rd_lo | input | 32 | Even register value |
| rf_rd_hi | input | 32 | Odd register value |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Access complete; response fields valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Bus error on this access |
| rf_we | output | 1 | Pair write enable |
| rf_wr_idx | output | 5 | Even register index written |
| rf_wr_lo | output | 32 | Value for the even register |
| rf_wr_hi | output | 32 | Value for the odd register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Bus error completion pulse |
| illegal | output | 1 | Odd pair rejection pulse |
| fault_addr | output | 32 | Address of the failing half |

## Verification
The bench holds `req_valid` high with a new request while a previous operation is still running. This makes a possible acceptance coincide with the final completion cycle of the earlier operation. It is judged by comparing `req_ready` and the bus every cycle against the reference model, which takes the new request only once the old one has finished.

The bench also aligns a bus error with the high half of both a load and a store. At that point the fault path and the commit path compete. It checks that `fault` appears with the correct address while `rf_wr_*` stays silent. In the store case, the first word must still have landed in memory.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC_LO,
    ST_ACC_HI,
    ST_COMMIT,
    ST_FAULT
  } pls_state_e;
endpackage

// File: rtl/pls_ctrl.sv
module pls_ctrl
  import pls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       pair_odd,
  input  logic       mem_ready,
  input  logic       mem_err,
  output pls_state_e state_o,
  output logic       ill_o
);
  pls_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = pair_odd ? ST_FAULT : ST_ACC_LO;
      ST_ACC_LO: if (mem_ready) st_d = mem_err ? ST_FAULT : ST_ACC_HI;
      ST_ACC_HI: if (mem_ready) st_d = mem_err ? ST_FAULT : ST_COMMIT;
      ST_COMMIT: st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ill_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) ill_o <= pair_odd;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/pls_data.sv
module pls_data #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_store,
  input  logic [DATA_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [IDX_W-1:0]  req_pair,
  input  logic [DATA_W-1:0] rf_rd_lo,
  input  logic [DATA_W-1:0] rf_rd_hi,
  input  logic              phase_hi,
  input  logic              lo_ok,
  input  logic              hi_ok,
  input  logic              any_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              is_store,
  output logic [IDX_W-1:0]  pair,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_lo,
  output logic [DATA_W-1:0] word_hi,
  output logic [DATA_W-1:0] err_addr
);
  localparam int STEP = DATA_W / 8;

  function automatic logic [DATA_W-1:0] first_addr(input logic [DATA_W-1:0] b,
                                                   input logic [OFF_W-1:0]  o);
    return b + {{(DATA_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [DATA_W-1:0] second_addr(input logic [DATA_W-1:0] a);
    return a + DATA_W'(STEP);
  endfunction

  logic [DATA_W-1:0] ea_q, st_lo_q, st_hi_q;
  logic              zero_pair;

  assign zero_pair = (req_pair == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q     <= '0;
      st_lo_q  <= '0;
      st_hi_q  <= '0;
      word_lo  <= '0;
      word_hi  <= '0;
      err_addr <= '0;
      is_store <= 1'b0;
      pair     <= '0;
    end else begin
      if (accept) begin
        ea_q     <= first_addr(req_base, req_offset);
        is_store <= req_store;
        pair     <= req_pair;
        st_lo_q  <= zero_pair ? '0 : rf_rd_lo;
        st_hi_q  <= zero_pair ? '0 : rf_rd_hi;
      end
      if (lo_ok)   word_lo  <= mem_rdata;
      if (hi_ok)   word_hi  <= mem_rdata;
      if (any_err) err_addr <= addr;
    end
  end

  assign addr  = phase_hi ? second_addr(ea_q) : ea_q;
  assign wdata = phase_hi ? st_hi_q : st_lo_q;
endmodule

// File: rtl/pair_ldst_seq.sv
module pair_ldst_seq
  import pls_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [DATA_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [IDX_W-1:0]  req_pair,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_lo,
  input  logic [DATA_W-1:0] rf_rd_hi,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_lo,
  output logic [DATA_W-1:0] rf_wr_hi,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              illegal,
  output logic [DATA_W-1:0] fault_addr
);
  pls_state_e state;
  logic       ill_q, accept, phase_lo, phase_hi, lo_ok, hi_ok, any_err, is_store;
  logic [IDX_W-1:0] pair_q;

  assign accept   = req_valid && req_ready;
  assign phase_lo = (state == ST_ACC_LO);
  assign phase_hi = (state == ST_ACC_HI);
  assign lo_ok    = phase_lo && mem_ready && !mem_err;
  assign hi_ok    = phase_hi && mem_ready && !mem_err;
  assign any_err  = (phase_lo || phase_hi) && mem_ready && mem_err;

  pls_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pair_odd(req_pair[0]),
    .mem_ready(mem_ready), .mem_err(mem_err), .state_o(state), .ill_o(ill_q)
  );

  pls_data #(.DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_store(req_store),
    .req_base(req_base), .req_offset(req_offset), .req_pair(req_pair),
    .rf_rd_lo(rf_rd_lo), .rf_rd_hi(rf_rd_hi), .phase_hi(phase_hi),
    .lo_ok(lo_ok), .hi_ok(hi_ok), .any_err(any_err), .mem_rdata(mem_rdata),
    .is_store(is_store), .pair(pair_q), .addr(mem_addr), .wdata(mem_wdata),
    .word_lo(rf_wr_lo), .word_hi(rf_wr_hi), .err_addr(fault_addr)
  );

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign rf_rd_idx = req_pair;
  assign mem_valid = phase_lo || phase_hi;
  assign mem_we    = is_store;
  assign done      = (state == ST_COMMIT);
  assign rf_we     = done && !is_store && (pair_q != '0);
  assign rf_wr_idx = pair_q;
  assign fault     = (state == ST_FAULT) && !ill_q;
  assign illegal   = (state == ST_FAULT) && ill_q;
endmodule

// File: rtl/pls_sva.sv
module pls_sva #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IDX_W-1:0]  req_pair,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_err,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              phase_hi,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_wr_idx,
  input logic              fault,
  input logic              illegal
);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_hi_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_err && !phase_hi) |=>
      (mem_valid && mem_addr == $past(mem_addr) + DATA_W'(4)));

  p_commit_after_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($past(mem_ready) && !$past(mem_err) && $past(phase_hi)));

  p_err_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err) |=> (fault && !rf_we));

  p_x0_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_wr_idx != '0));

  p_odd_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_pair[0]) |=> (illegal && !mem_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind pair_ldst_seq pls_sva #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pair(req_pair), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_err(mem_err), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .phase_hi(phase_hi), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .fault(fault),
  .illegal(illegal)
);

// File: tb/pair_ldst_seq_test.sv
module pair_ldst_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_base = '0;
  logic [11:0] req_offset = '0;
  logic [4:0]  req_pair = '0;
  logic        req_ready, mem_valid, mem_we, mem_ready, mem_err;
  logic [4:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_lo, rf_rd_hi, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] rf_wr_lo, rf_wr_hi, fault_addr;
  logic        rf_we, busy, done, fault, illegal;

  logic [31:0] rf  [32];
  logic [31:0] mem [64];
  int          lat = 0, wcnt = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_at = '0;
  int          n_chk = 0, n_fail = 0;

  pair_ldst_seq uut (.*);

  assign rf_rd_lo  = rf[rf_rd_idx];
  assign rf_rd_hi  = rf[rf_rd_idx | 5'd1];
  assign mem_ready = mem_valid && (wcnt >= lat);
  assign mem_err   = mem_ready && err_en && (mem_addr == err_at);
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (mem_valid && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_valid && mem_ready && mem_we && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
    if (rf_we) begin
      rf[rf_wr_idx] <= rf_wr_lo;
      rf[rf_wr_idx | 5'd1] <= rf_wr_hi;
    end
  end

  // reference model: phase 0 idle, 1 low half, 2 high half, 3 success, 4 bus fault, 5 illegal
  int          m_ph = 0;
  logic        m_st = 1'b0;
  logic [4:0]  m_pair = '0;
  logic [31:0] m_ea = '0, m_lo = '0, m_hi = '0, m_wlo = '0, m_whi = '0, m_fa = '0;

  always @(posedge clk) begin
    if (!rst_n) m_ph <= 0;
    else case (m_ph)
      0: if (req_valid) begin
           m_st   <= req_store;
           m_pair <= req_pair;
           m_ea   <= req_base + {{20{req_offset[11]}}, req_offset};
           m_wlo  <= (req_pair == 0) ? 32'd0 : rf[req_pair];
           m_whi  <= (req_pair == 0) ? 32'd0 : rf[req_pair + 5'd1];
           m_ph   <= req_pair[0] ? 5 : 1;
         end
      1: if (mem_ready) begin
           if (mem_err) begin m_fa <= m_ea; m_ph <= 4; end
           else begin m_lo <= mem_rdata; m_ph <= 2; end
         end
      2: if (mem_ready) begin
           if (mem_err) begin m_fa <= m_ea + 32'd4; m_ph <= 4; end
           else begin m_hi <= mem_rdata; m_ph <= 3; end
         end
      default: m_ph <= 0;
    endcase
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_ph == 0), "R1 req_ready", 32'(req_ready), 32'(m_ph == 0));
      chk(busy == (m_ph != 0), "R1 busy", 32'(busy), 32'(m_ph != 0));
      chk(mem_valid == (m_ph == 1 || m_ph == 2), "R8/R10 mem_valid", 32'(mem_valid), 32'(m_ph == 1 || m_ph == 2));
      if (m_ph == 1 || m_ph == 2) begin
        chk(mem_addr == (m_ph == 2 ? m_ea + 32'd4 : m_ea), "R2 mem_addr", mem_addr, m_ph == 2 ? m_ea + 32'd4 : m_ea);
        chk(mem_we == m_st, "R3 mem_we", 32'(mem_we), 32'(m_st));
        if (m_st) chk(mem_wdata == (m_ph == 2 ? m_whi : m_wlo), "R3 mem_wdata", mem_wdata, m_ph == 2 ? m_whi : m_wlo);
      end
      chk(rf_we == (m_ph == 3 && !m_st && m_pair != 0), "R4 rf_we", 32'(rf_we), 32'(m_ph == 3 && !m_st && m_pair != 0));
      if (m_ph == 3 && !m_st && m_pair != 0) begin
        chk(rf_wr_idx == m_pair, "R4 rf_wr_idx", 32'(rf_wr_idx), 32'(m_pair));
        chk(rf_wr_lo == m_lo, "R4 rf_wr_lo", rf_wr_lo, m_lo);
        chk(rf_wr_hi == m_hi, "R4 rf_wr_hi", rf_wr_hi, m_hi);
      end
      chk(done == (m_ph == 3), "R9 done", 32'(done), 32'(m_ph == 3));
      chk(fault == (m_ph == 4), "R5 fault", 32'(fault), 32'(m_ph == 4));
      if (m_ph == 4) chk(fault_addr == m_fa, "R5 fault_addr", fault_addr, m_fa);
      chk(illegal == (m_ph == 5), "R7 illegal", 32'(illegal), 32'(m_ph == 5));
    end
  end

  task automatic issue(input logic st, input logic [31:0] b, input logic [11:0] o, input logic [4:0] p);
    @(negedge clk);
    req_store = st; req_base = b; req_offset = o; req_pair = p; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [31:0] e0, e1, e2, e3;
  initial begin
    for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? 32'd0 : 32'h1100_0000 + 32'(i) * 32'h0001_0101;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | (32'(i) << 4) | 32'h3;
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !mem_valid && !rf_we, "R1 reset idle", 32'(busy), 32'd0);
    rst_n = 1'b1;

    // R4: load, zero latency
    e0 = mem[18]; e1 = mem[19];
    issue(1'b0, 32'h40, 12'd8, 5'd10); wait_idle();
    chk(rf[10] == e0, "R4 even reg", rf[10], e0);
    chk(rf[11] == e1, "R4 odd reg", rf[11], e1);

    // R2 negative offset, R8 latency 2
    lat = 2; e0 = mem[10]; e1 = mem[11];
    issue(1'b0, 32'h38, 12'hFF0, 5'd20); wait_idle();
    chk(rf[20] == e0 && rf[21] == e1, "R2 negative offset load", rf[20], e0);

    // R3 store
    lat = 1; e0 = rf[12]; e1 = rf[13];
    issue(1'b1, 32'h80, 12'hFF0, 5'd12); wait_idle();
    chk(mem[28] == e0, "R3 store low word", mem[28], e0);
    chk(mem[29] == e1, "R3 store high word", mem[29], e1);

    // R3 store of x0 pair sends zeros
    issue(1'b1, 32'h20, 12'd0, 5'd0); wait_idle();
    chk(mem[8] == 0 && mem[9] == 0, "R3 x0 store zeros", mem[9], 32'd0);

    // R6 load to x0
    lat = 0; e0 = rf[1];
    issue(1'b0, 32'h30, 12'd0, 5'd0); wait_idle();
    chk(rf[1] == e0 && rf[0] == 0, "R6 x1 untouched", rf[1], e0);

    // R7 odd pair
    e0 = rf[7];
    issue(1'b0, 32'h40, 12'd0, 5'd7); wait_idle();
    chk(rf[7] == e0, "R7 odd pair no write", rf[7], e0);

    // R5 / R10 fault on low half of a load
    err_en = 1'b1; err_at = 32'h50; e0 = rf[14]; e1 = rf[15];
    issue(1'b0, 32'h50, 12'd0, 5'd14); wait_idle();
    chk(rf[14] == e0 && rf[15] == e1, "R5 lo fault no write", rf[14], e0);

    // R5 fault on high half of a load
    err_at = 32'h64; lat = 1; e0 = rf[16]; e1 = rf[17];
    issue(1'b0, 32'h60, 12'd0, 5'd16); wait_idle();
    chk(rf[16] == e0 && rf[17] == e1, "R5 hi fault no write", rf[17], e1);

    // R10 store faulting on high half
    err_at = 32'h94; e0 = rf[18]; e1 = mem[37];
    issue(1'b1, 32'h90, 12'd0, 5'd18); wait_idle();
    chk(mem[36] == e0, "R10 first store half kept", mem[36], e0);
    chk(mem[37] == e1, "R10 second store half absent", mem[37], e1);
    err_en = 1'b0;

    // R1 back-to-back with request held during busy
    e0 = mem[40]; e1 = mem[41]; e2 = mem[44]; e3 = mem[45];
    issue(1'b0, 32'hA0, 12'd0, 5'd22);
    issue(1'b0, 32'hB0, 12'd0, 5'd24);
    wait_idle();
    chk(rf[22] == e0 && rf[23] == e1, "R1 first of pair", rf[22], e0);
    chk(rf[24] == e2 && rf[25] == e3, "R1 second of pair", rf[24], e2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule